// File: doc/BRIEF.md
# Timer Interrupt Reinjection Gate

This block sits between a periodic timer tick and an interrupt controller. Each tick that reaches it is added to a count of undelivered expiries. The block does not raise one interrupt per tick. It releases a single one-cycle interrupt pulse when the controller offers a delivery slot, and only if two things hold: at least one expiry is outstanding, and the previous pulse has been acknowledged. Ticks that arrive while delivery is held up are therefore not lost. They are replayed one at a time, and each replay waits for its own acknowledge.

An internal flag records whether the last pulse has been acknowledged. An acknowledge sets this flag and retires one outstanding expiry. Unmasking the interrupt line, or reprogramming the timer period, discards every outstanding expiry and reopens the gate. The pulse rises for one cycle and then falls, which gives an edge-sensitive controller the edge it needs.

Top module: `tick_reinject_gate`

## Requirements
- R1: After reset, `pending_o` is 0 and `irq_o` is low, and the acknowledged flag is set, so the first delivery slot after a tick produces a pulse.
- R2: A cycle with `tick_i` high, and with none of `ack_i`, `unmask_i` or `reprog_i` high, raises `pending_o` by one on the next cycle.
- R3: `pending_o` saturates at 2^CNT_W-1. A further tick leaves it at that value rather than wrapping.
- R4: When `deliver_i` is high, `pending_o` is nonzero and the acknowledged flag is set, `irq_o` is high in the next cycle for exactly one cycle. The pulse itself does not change `pending_o`.
- R5: A delivery slot while `pending_o` is 0 produces no pulse.
- R6: After a pulse, delivery slots produce no further pulse until `ack_i` is seen.
- R7: `ack_i` sets the acknowledged flag and lowers `pending_o` by one. When `pending_o` is already 0, it stays at 0.
- R8: When `tick_i` and `ack_i` are high in the same cycle, `pending_o` does not change and the acknowledged flag is set.
- R9: `unmask_i` clears `pending_o` to 0 and sets the acknowledged flag on the next cycle. It overrides a tick, an acknowledge or a delivery slot in the same cycle, and no pulse follows from that cycle.
- R10: `reprog_i` has the same effect as `unmask_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer expiry strobe |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| deliver_i | input | 1 | Delivery opportunity strobe from the controller |
| unmask_i | input | 1 | Interrupt line has just been unmasked |
| reprog_i | input | 1 | Timer period has been reprogrammed |
| irq_o | output | 1 | One-cycle interrupt pulse |
| pending_o | output | CNT_W | Count of outstanding expiries |

## Verification
The bench targets the following corner cases, each with the fault it would expose:
- **Delivery slots after a pulse:** repeated slots before any acknowledge would yield a burst of interrupts in a design that fails to close the gate.
- **Acknowledge at a count of zero:** a design without a floor would wrap to the maximum count and then flood the controller.
- **Tick and acknowledge in the same cycle:** a design that lets one strobe win would drift the count by one.
- **Long runs of ticks:** a counter that wraps instead of saturating would drop to zero here.
- **Unmask or reprogram in the same cycle as a tick or a slot:** a clear that loses priority would leave a stale expiry or emit a spurious pulse.

// File: rtl/tick_reinject_gate.sv
module tick_reinject_gate #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ack_i,
  input  logic             deliver_i,
  input  logic             unmask_i,
  input  logic             reprog_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] pending_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic acked_q;
  logic clear;
  logic has_pend;
  logic fire;

  assign clear    = unmask_i | reprog_i;
  assign has_pend = |pending_o;
  assign fire     = deliver_i & acked_q & has_pend & ~clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_o <= '0;
      acked_q   <= 1'b1;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= fire;
      if (clear) begin
        pending_o <= '0;
        acked_q   <= 1'b1;
      end else begin
        case ({tick_i, ack_i})
          2'b10:   if (pending_o != CNT_MAX) pending_o <= pending_o + 1'b1;
          2'b01:   if (has_pend) pending_o <= pending_o - 1'b1;
          default: ;
        endcase
        if (ack_i)     acked_q <= 1'b1;
        else if (fire) acked_q <= 1'b0;
      end
    end
  end

  // R9 R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pending_o == '0) && !irq_o);

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o == CNT_MAX) && tick_i && !ack_i && !clear |=> pending_o == CNT_MAX);

  // R7
  ack_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o == '0) && ack_i && !tick_i && !clear |=> pending_o == '0);

  // R8
  tick_ack_net_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && ack_i && !clear |=> $stable(pending_o));

  // R4 R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(deliver_i) && ($past(pending_o) != '0));

  // R6
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !ack_i && !clear |=> !irq_o);
endmodule

// File: tb/tick_reinject_gate_tb.sv
`timescale 1ns/1ps
module tick_reinject_gate_tb;
  localparam int W = 4;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst_n, tick_i, ack_i, deliver_i, unmask_i, reprog_i;
  logic irq_o;
  logic [W-1:0] pending_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tick_reinject_gate #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ack_i(ack_i),
    .deliver_i(deliver_i), .unmask_i(unmask_i), .reprog_i(reprog_i),
    .irq_o(irq_o), .pending_o(pending_o)
  );

  // {tick, ack, deliver, unmask, reprog, exp_irq, exp_pend[3:0], req[3:0]}
  localparam logic [13:0] VEC [NV] = '{
    14'b00100_0_0000_0101, // R5 slot with nothing pending
    14'b10000_0_0001_0010, // R2
    14'b10000_0_0010_0010, // R2
    14'b00100_1_0010_0100, // R4 pulse
    14'b00000_0_0010_0100, // R4 one cycle only
    14'b00100_0_0010_0110, // R6 gate closed
    14'b01000_0_0001_0111, // R7 decrement
    14'b00100_1_0001_0111, // R7 flag reopened
    14'b01000_0_0000_0111, // R7
    14'b01000_0_0000_0111, // R7 floor at zero
    14'b00100_0_0000_0101, // R5
    14'b11000_0_0000_1000, // R8 at zero
    14'b10000_0_0001_0010, // R2
    14'b11000_0_0001_1000, // R8 net zero
    14'b00100_1_0001_1000, // R8 flag set
    14'b10000_0_0010_0010, // R2
    14'b10110_0_0000_1001, // R9 clear dominates
    14'b10000_0_0001_0010, // R2
    14'b00100_1_0001_1001, // R9 flag set after clear
    14'b00001_0_0000_1010, // R10
    14'b10000_0_0001_0010, // R2
    14'b00100_1_0001_1010  // R10 flag set
  };

  task automatic drive(input logic t, a, d, u, r);
    tick_i = t; ack_i = a; deliver_i = d; unmask_i = u; reprog_i = r;
    @(negedge clk);
  endtask

  task automatic check(input int req, input logic ei, input logic [W-1:0] ep);
    checks++;
    if (irq_o !== ei || pending_o !== ep) begin
      fails++;
      $display("FAIL R%0d: irq=%0b pending=%0d, expected irq=%0b pending=%0d",
               req, irq_o, pending_o, ei, ep);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    tick_i = 0; ack_i = 0; deliver_i = 0; unmask_i = 0; reprog_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(1, 1'b0, '0); // R1 reset state

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9]);
      check(int'(VEC[i][3:0]), VEC[i][8], VEC[i][7:4]);
    end

    // R3 saturation
    for (int i = 0; i < 20; i++) drive(1, 0, 0, 0, 0);
    check(3, 1'b0, 4'd15);
    drive(1, 0, 0, 0, 0);
    check(3, 1'b0, 4'd15);
    drive(0, 1, 0, 0, 0);
    check(7, 1'b0, 4'd14);

    // R6 repeated slots after a pulse
    drive(0, 0, 1, 0, 0);
    check(4, 1'b1, 4'd14);
    for (int i = 0; i < 3; i++) begin
      drive(0, 0, 1, 0, 0);
      check(6, 1'b0, 4'd14);
    end

    // R1 reset mid-run reopens the gate
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0);
    rst_n = 1'b1;
    check(1, 1'b0, '0);
    drive(1, 0, 1, 0, 0);
    check(5, 1'b0, 4'd1);
    drive(0, 0, 1, 0, 0);
    check(1, 1'b1, 4'd1);
    drive(0, 0, 0, 0, 0);
    check(4, 1'b0, 4'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule